// File: doc/BRIEF.md
# Subband Scan and Rendezvous Controller

This controller moves a receiver across a programmable set of overlapping frequency subbands until it finds a transmitter, and then keeps the link. For each subband it sends the front end a one-cycle tune request that carries that subband's centre frequency word. It waits for the synthesizer to settle, starts spectral sensing and reads the detection result. When a carrier is detected, it enables carrier lock and waits for the demodulator to confirm the known preamble. After the preamble is confirmed, it stays on the channel and samples a link-health input at a fixed interval.

Any of three outcomes moves the scan to the next subband: sensing finds nothing, the preamble check fails or times out, or the link is declared lost. After the last active subband the scan wraps to subband 0. Because the subbands overlap, a carrier that straddles one subband edge still lies whole inside a neighbouring subband. The number of active subbands and every centre word are programmable. Band-count values above the table size are treated as the table size.

Top module: `scan_rendezvous_ctrl`

## Requirements
- R1: While reset is asserted, stateCode is 0, bandIdx is 0, locked is 0 and tuneStrobe is 0. In the first cycle after reset is released, tuneStrobe is 1 and tuneWord holds the word stored for subband 0.
- R2: tuneStrobe is high for exactly one cycle per tune request. tuneWord then equals the table entry for bandIdx. Entries are written through tblWrEn/tblWrIdx/tblWrData.
- R3: After a tune request, senseStart pulses in the cycle after tuneDone is seen. Without tuneDone, senseStart pulses max(cfgSettle,1)+1 cycles after the tune cycle.
- R4: In the sense-wait state, senseDone with senseDetect=0 advances the subband and issues a new tune request in the next cycle. senseDone with senseDetect=1 enters preamble verification.
- R5: A preamble result with preambleOk=0 advances the subband. With no result, verification times out after max(cfgVerifyTimeout,1) cycles and also advances the subband.
- R6: A preamble result with preambleOk=1 enters monitoring with locked=1. A result that arrives in the timeout cycle takes precedence over the timeout.
- R7: While monitoring, linkOk is sampled once every max(cfgMonInterval,1) cycles. max(cfgLossLimit,1) consecutive failed samples declare loss and advance the subband. A good sample clears the failure run.
- R8: An advance from the last active subband (cfgBandCount-1) goes to subband 0. Otherwise the subband index increments by one. A cfgBandCount of 0 is treated as 1.
- R9: stateCode takes these values: 0 = tune, 1 = settle, 2 = sense request, 3 = sense wait, 4 = verify, 5 = monitor. locked is 1 only in monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgBandCount | input | 5 | Number of active subbands (0 is treated as 1, clamped to 16) |
| cfgSettle | input | 16 | Settle wait in cycles after a tune request |
| cfgVerifyTimeout | input | 16 | Preamble verification timeout in cycles |
| cfgMonInterval | input | 16 | Link sampling period in cycles |
| cfgLossLimit | input | 4 | Consecutive failed samples that declare loss |
| tblWrEn | input | 1 | Centre-word table write enable |
| tblWrIdx | input | 4 | Table entry to write |
| tblWrData | input | 24 | Centre frequency word to store |
| tuneDone | input | 1 | Front end reports the synthesizer has settled |
| senseDone | input | 1 | Sensing result valid |
| senseDetect | input | 1 | Sensing found a carrier |
| preambleValid | input | 1 | Preamble check result valid |
| preambleOk | input | 1 | Preamble matched |
| linkOk | input | 1 | Current link-health indication |
| tuneStrobe | output | 1 | One-cycle tune request |
| tuneWord | output | 24 | Frequency word for the current subband |
| senseStart | output | 1 | One-cycle sensing start pulse |
| stateCode | output | 3 | Controller state code |
| bandIdx | output | 4 | Current subband index |
| locked | output | 1 | Link established and under monitoring |

## Verification
In the verify state, the preamble result and the verification timeout can fall in the same cycle. The bench provokes this by counting cycles from the detection pulse and presenting a good preamble exactly when the timer reaches the timeout value. It judges the outcome at the ports: locked must be high in the following cycle, and no tune request may appear. A second coincidence is a good link sample arriving between two failed samples. The bench confirms that such a run does not declare loss.

// File: rtl/scan_rdv_pkg.sv
package scan_rdv_pkg;

  typedef enum logic [2:0] {
    ST_TUNE       = 3'd0,
    ST_SETTLE     = 3'd1,
    ST_SENSE_REQ  = 3'd2,
    ST_SENSE_WAIT = 3'd3,
    ST_VERIFY     = 3'd4,
    ST_MONITOR    = 3'd5
  } scanState_e;

  typedef enum logic [1:0] {
    LIM_SETTLE  = 2'd0,
    LIM_VERIFY  = 2'd1,
    LIM_MONITOR = 2'd2
  } limSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;   // restart the shared cycle timer at 1
    logic advance;    // step to the next subband (with wrap)
    logic monSample;  // take one link-health sample
    logic clrFail;    // clear the consecutive failure run
  } ctlStrobes_t;

endpackage

// File: rtl/scan_rdv_datapath.sv
module scan_rdv_datapath
  import scan_rdv_pkg::*;
#(
  parameter int MAX_BANDS = 16,
  parameter int FREQ_W    = 24,
  parameter int CNT_W     = 16,
  parameter int FAIL_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ctlStrobes_t                    ctl,
  input  limSel_e                        limSel,
  input  logic [$clog2(MAX_BANDS+1)-1:0] cfgBandCount,
  input  logic [CNT_W-1:0]               cfgSettle,
  input  logic [CNT_W-1:0]               cfgVerifyTimeout,
  input  logic [CNT_W-1:0]               cfgMonInterval,
  input  logic [FAIL_W-1:0]              cfgLossLimit,
  input  logic                           tblWrEn,
  input  logic [$clog2(MAX_BANDS)-1:0]   tblWrIdx,
  input  logic [FREQ_W-1:0]              tblWrData,
  input  logic                           linkOk,
  output logic [$clog2(MAX_BANDS)-1:0]   bandIdx,
  output logic [FREQ_W-1:0]              tuneWord,
  output logic                           timerHit,
  output logic                           failFinal
);

  localparam int IDX_W  = $clog2(MAX_BANDS);
  localparam int CNTB_W = $clog2(MAX_BANDS + 1);

  // centre-word table: plain registers, written from outside
  logic [FREQ_W-1:0] freqTable [MAX_BANDS];

  always_ff @(posedge clk) begin
    if (tblWrEn) freqTable[tblWrIdx] <= tblWrData;
  end

  assign tuneWord = freqTable[bandIdx];

  // effective subband count and last index
  logic [CNTB_W-1:0] effCount;
  logic [IDX_W-1:0]  lastIdx;

  always_comb begin
    if (cfgBandCount == '0)
      effCount = CNTB_W'(1);
    else if (cfgBandCount > CNTB_W'(MAX_BANDS))
      effCount = CNTB_W'(MAX_BANDS);
    else
      effCount = cfgBandCount;
  end

  assign lastIdx = IDX_W'(effCount - CNTB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bandIdx <= '0;
    else if (ctl.advance)
      bandIdx <= (bandIdx >= lastIdx) ? '0 : bandIdx + IDX_W'(1);
  end

  // shared timer for settle, verify timeout and monitor interval
  logic [CNT_W-1:0] cycTimer;
  logic [CNT_W-1:0] limRaw;
  logic [CNT_W-1:0] limEff;

  always_comb begin
    unique case (limSel)
      LIM_VERIFY:  limRaw = cfgVerifyTimeout;
      LIM_MONITOR: limRaw = cfgMonInterval;
      default:     limRaw = cfgSettle;
    endcase
    limEff = (limRaw == '0) ? CNT_W'(1) : limRaw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cycTimer <= CNT_W'(1);
    else if (ctl.clrTimer)
      cycTimer <= CNT_W'(1);
    else if (cycTimer != '1)
      cycTimer <= cycTimer + CNT_W'(1);
  end

  assign timerHit = (cycTimer >= limEff);

  // consecutive link failure run
  logic [FAIL_W-1:0] failCnt;
  logic [FAIL_W-1:0] effLoss;

  assign effLoss = (cfgLossLimit == '0) ? FAIL_W'(1) : cfgLossLimit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      failCnt <= '0;
    else if (ctl.clrFail || ctl.advance)
      failCnt <= '0;
    else if (ctl.monSample) begin
      if (linkOk)
        failCnt <= '0;
      else if (failCnt != '1)
        failCnt <= failCnt + FAIL_W'(1);
    end
  end

  // a failing sample now would complete the run
  assign failFinal = !linkOk &&
    (({1'b0, failCnt} + (FAIL_W+1)'(1)) >= {1'b0, effLoss});

  // R8: wrap after the last active subband
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && bandIdx >= lastIdx) |=> (bandIdx == '0));

  // R8: plain step otherwise
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && bandIdx < lastIdx) |=> (bandIdx == $past(bandIdx) + IDX_W'(1)));

  // R8: index holds without an advance
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.advance |=> $stable(bandIdx));

  // R7: a good sample breaks the failure run
  p_fail_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.monSample && linkOk) |=> (failCnt == '0));

endmodule

// File: rtl/scan_rdv_fsm.sv
module scan_rdv_fsm
  import scan_rdv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tuneDone,
  input  logic        senseDone,
  input  logic        senseDetect,
  input  logic        preambleValid,
  input  logic        preambleOk,
  input  logic        timerHit,
  input  logic        failFinal,
  output ctlStrobes_t ctl,
  output limSel_e     limSel,
  output scanState_e  state,
  output logic        tuneStrobe,
  output logic        senseStart,
  output logic        locked
);

  scanState_e nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_TUNE;
    else        state <= nextState;
  end

  always_comb begin
    unique case (state)
      ST_VERIFY:  limSel = LIM_VERIFY;
      ST_MONITOR: limSel = LIM_MONITOR;
      default:    limSel = LIM_SETTLE;
    endcase
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_TUNE: begin
        ctl.clrTimer = 1'b1;
        nextState    = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tuneDone || timerHit) nextState = ST_SENSE_REQ;
      end
      ST_SENSE_REQ: begin
        nextState = ST_SENSE_WAIT;
      end
      ST_SENSE_WAIT: begin
        if (senseDone) begin
          if (senseDetect) begin
            ctl.clrTimer = 1'b1;
            nextState    = ST_VERIFY;
          end else begin
            ctl.advance = 1'b1;
            nextState   = ST_TUNE;
          end
        end
      end
      ST_VERIFY: begin
        // a result present in the timeout cycle outranks the timeout
        if (preambleValid) begin
          if (preambleOk) begin
            ctl.clrTimer = 1'b1;
            ctl.clrFail  = 1'b1;
            nextState    = ST_MONITOR;
          end else begin
            ctl.advance = 1'b1;
            nextState   = ST_TUNE;
          end
        end else if (timerHit) begin
          ctl.advance = 1'b1;
          nextState   = ST_TUNE;
        end
      end
      ST_MONITOR: begin
        if (timerHit) begin
          ctl.monSample = 1'b1;
          ctl.clrTimer  = 1'b1;
          if (failFinal) begin
            ctl.advance = 1'b1;
            nextState   = ST_TUNE;
          end
        end
      end
      default: begin
        ctl.advance = 1'b1;
        nextState   = ST_TUNE;
      end
    endcase
  end

  assign tuneStrobe = rst_n && (state == ST_TUNE);
  assign senseStart = (state == ST_SENSE_REQ);
  assign locked     = (state == ST_MONITOR);

  // R2: tune request lasts one cycle
  p_tune_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tuneStrobe |=> !tuneStrobe);

  // R3: a tune request is followed by the settle wait
  p_tune_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tuneStrobe |=> (state == ST_SETTLE));

  // R3: sensing start is followed by the wait for its result
  p_sense_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    senseStart |=> (state == ST_SENSE_WAIT));

  // R4: detection leads into verification
  p_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SENSE_WAIT && senseDone && senseDetect) |=> (state == ST_VERIFY));

  // R4: no detection leads to a new tune request
  p_nodetect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SENSE_WAIT && senseDone && !senseDetect) |=> tuneStrobe);

  // R5: a failed preamble leads to a new tune request
  p_bad_preamble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VERIFY && preambleValid && !preambleOk) |=> tuneStrobe);

  // R6: a good preamble locks, even in the timeout cycle
  p_result_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VERIFY && preambleValid && preambleOk) |=> locked);

endmodule

// File: rtl/scan_rendezvous_ctrl.sv
module scan_rendezvous_ctrl
  import scan_rdv_pkg::*;
#(
  parameter int MAX_BANDS = 16,
  parameter int FREQ_W    = 24,
  parameter int CNT_W     = 16,
  parameter int FAIL_W    = 4,
  localparam int IDX_W    = $clog2(MAX_BANDS),
  localparam int CNTB_W   = $clog2(MAX_BANDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNTB_W-1:0] cfgBandCount,
  input  logic [CNT_W-1:0]  cfgSettle,
  input  logic [CNT_W-1:0]  cfgVerifyTimeout,
  input  logic [CNT_W-1:0]  cfgMonInterval,
  input  logic [FAIL_W-1:0] cfgLossLimit,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic [FREQ_W-1:0] tblWrData,
  input  logic              tuneDone,
  input  logic              senseDone,
  input  logic              senseDetect,
  input  logic              preambleValid,
  input  logic              preambleOk,
  input  logic              linkOk,
  output logic              tuneStrobe,
  output logic [FREQ_W-1:0] tuneWord,
  output logic              senseStart,
  output logic [2:0]        stateCode,
  output logic [IDX_W-1:0]  bandIdx,
  output logic              locked
);

  ctlStrobes_t ctl;
  limSel_e     limSel;
  scanState_e  state;
  logic        timerHit;
  logic        failFinal;

  scan_rdv_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tuneDone     (tuneDone),
    .senseDone    (senseDone),
    .senseDetect  (senseDetect),
    .preambleValid(preambleValid),
    .preambleOk   (preambleOk),
    .timerHit     (timerHit),
    .failFinal    (failFinal),
    .ctl          (ctl),
    .limSel       (limSel),
    .state        (state),
    .tuneStrobe   (tuneStrobe),
    .senseStart   (senseStart),
    .locked       (locked)
  );

  scan_rdv_datapath #(
    .MAX_BANDS(MAX_BANDS),
    .FREQ_W   (FREQ_W),
    .CNT_W    (CNT_W),
    .FAIL_W   (FAIL_W)
  ) u_dp (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctl             (ctl),
    .limSel          (limSel),
    .cfgBandCount    (cfgBandCount),
    .cfgSettle       (cfgSettle),
    .cfgVerifyTimeout(cfgVerifyTimeout),
    .cfgMonInterval  (cfgMonInterval),
    .cfgLossLimit    (cfgLossLimit),
    .tblWrEn         (tblWrEn),
    .tblWrIdx        (tblWrIdx),
    .tblWrData       (tblWrData),
    .linkOk          (linkOk),
    .bandIdx         (bandIdx),
    .tuneWord        (tuneWord),
    .timerHit        (timerHit),
    .failFinal       (failFinal)
  );

  assign stateCode = state;

endmodule

// File: tb/sim_scan_rendezvous_ctrl.sv
module sim_scan_rendezvous_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cfgBandCount;
  logic [15:0] cfgSettle, cfgVerifyTimeout, cfgMonInterval;
  logic [3:0]  cfgLossLimit;
  logic        tblWrEn;
  logic [3:0]  tblWrIdx;
  logic [23:0] tblWrData;
  logic        tuneDone, senseDone, senseDetect, preambleValid, preambleOk, linkOk;
  logic        tuneStrobe, senseStart, locked;
  logic [23:0] tuneWord;
  logic [2:0]  stateCode;
  logic [3:0]  bandIdx;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  scan_rendezvous_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfgBandCount(cfgBandCount), .cfgSettle(cfgSettle),
    .cfgVerifyTimeout(cfgVerifyTimeout), .cfgMonInterval(cfgMonInterval),
    .cfgLossLimit(cfgLossLimit), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrData(tblWrData), .tuneDone(tuneDone), .senseDone(senseDone),
    .senseDetect(senseDetect), .preambleValid(preambleValid), .preambleOk(preambleOk),
    .linkOk(linkOk), .tuneStrobe(tuneStrobe), .tuneWord(tuneWord),
    .senseStart(senseStart), .stateCode(stateCode), .bandIdx(bandIdx), .locked(locked)
  );

  // {expected next band[5:2], mode[1:0]}: 0 no detect, 1 bad preamble, 2 timeout, 3 lock then loss
  localparam logic [5:0] VECS [6] = '{
    {4'd1, 2'd0}, {4'd2, 2'd1}, {4'd3, 2'd2},
    {4'd4, 2'd3}, {4'd0, 2'd0}, {4'd1, 2'd3}
  };

  function automatic logic [23:0] wordFor(input int i);
    return 24'h100000 + 24'(i) * 24'h001010;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts negedges until the chosen strobe is seen (1 = senseStart, 0 = tuneStrobe)
  task automatic waitFor(input bit wantSense, output int n);
    n = 1;
    @(negedge clk);
    while (((wantSense ? senseStart : tuneStrobe) == 1'b0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] expB;
    logic [1:0] md;
    rst_n = 1'b0;
    cfgBandCount = 5'd5; cfgSettle = 16'd4; cfgVerifyTimeout = 16'd6;
    cfgMonInterval = 16'd3; cfgLossLimit = 4'd2;
    tblWrEn = 1'b0; tblWrIdx = '0; tblWrData = '0;
    tuneDone = 0; senseDone = 0; senseDetect = 0; preambleValid = 0; preambleOk = 0;
    linkOk = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tblWrEn = 1'b1; tblWrIdx = 4'(i); tblWrData = wordFor(i);
    end
    @(negedge clk);
    tblWrEn = 1'b0;

    // R1 reset state
    chk(stateCode == 3'd0, "R1 reset stateCode", stateCode, 0);
    chk(bandIdx == 4'd0, "R1 reset bandIdx", bandIdx, 0);
    chk(locked == 1'b0, "R1 reset locked", locked, 0);
    chk(tuneStrobe == 1'b0, "R1 no strobe in reset", tuneStrobe, 0);

    rst_n = 1'b1;
    #1;
    chk(tuneStrobe == 1'b1, "R1 first tune after reset", tuneStrobe, 1);
    chk(tuneWord == wordFor(0), "R1 band0 word", tuneWord, wordFor(0));

    for (int v = 0; v < 6; v++) begin
      expB = VECS[v][5:2];
      md   = VECS[v][1:0];
      if (v % 2 == 0) begin
        @(negedge clk);
        chk(tuneStrobe == 1'b0, "R2 strobe one cycle", tuneStrobe, 0);
        tuneDone = 1'b1;
        @(negedge clk);
        tuneDone = 1'b0;
        chk(senseStart == 1'b1, "R3 tuneDone ends settle", senseStart, 1);
      end else begin
        waitFor(1'b1, n);
        chk(n == 5, "R3 settle count", n, 5);
      end
      @(negedge clk);
      chk(stateCode == 3'd3, "R9 sense wait code", stateCode, 3);
      senseDone = 1'b1;
      senseDetect = (md != 2'd0);
      @(negedge clk);
      senseDone = 1'b0;
      senseDetect = 1'b0;
      case (md)
        2'd0: chk(tuneStrobe == 1'b1, "R4 no detect advances", tuneStrobe, 1);
        2'd1: begin
          chk(stateCode == 3'd4, "R4 detect enters verify", stateCode, 4);
          preambleValid = 1'b1; preambleOk = 1'b0;
          @(negedge clk);
          preambleValid = 1'b0;
          chk(tuneStrobe == 1'b1, "R5 bad preamble advances", tuneStrobe, 1);
        end
        2'd2: begin
          chk(stateCode == 3'd4, "R4 detect enters verify", stateCode, 4);
          waitFor(1'b0, n);
          chk(n == 6, "R5 verify timeout", n, 6);
        end
        default: begin
          chk(stateCode == 3'd4, "R4 detect enters verify", stateCode, 4);
          preambleValid = 1'b1; preambleOk = 1'b1;
          @(negedge clk);
          preambleValid = 1'b0; preambleOk = 1'b0;
          chk(locked == 1'b1, "R6 preamble ok locks", locked, 1);
          chk(stateCode == 3'd5, "R9 monitor code", stateCode, 5);
          for (int j = 1; j <= 14; j++) begin
            linkOk = (j <= 5 || (j >= 9 && j <= 11)) ? 1'b0 : 1'b1;
            @(negedge clk);
          end
          chk(locked == 1'b1, "R7 non-consecutive failures keep lock", locked, 1);
          linkOk = 1'b0;
          waitFor(1'b0, n);
          chk(n == 4, "R7 loss after consecutive failures", n, 4);
          linkOk = 1'b1;
        end
      endcase
      chk(bandIdx == expB, "R8 next subband", bandIdx, expB);
      chk(tuneWord == wordFor(int'(expB)), "R2 tune word", tuneWord, wordFor(int'(expB)));
    end

    // R6 result in the timeout cycle wins
    waitFor(1'b1, n);
    @(negedge clk);
    senseDone = 1'b1; senseDetect = 1'b1;
    @(negedge clk);
    senseDone = 1'b0; senseDetect = 1'b0;
    repeat (5) @(negedge clk);
    preambleValid = 1'b1; preambleOk = 1'b1;
    @(negedge clk);
    preambleValid = 1'b0; preambleOk = 1'b0;
    chk(locked == 1'b1, "R6 result beats same-cycle timeout", locked, 1);
    chk(tuneStrobe == 1'b0, "R6 no tune on same-cycle result", tuneStrobe, 0);
    linkOk = 1'b0;
    waitFor(1'b0, n);
    linkOk = 1'b1;
    chk(bandIdx == 4'd2, "R8 band after loss", bandIdx, 2);

    // R8 zero band count behaves as one subband
    cfgBandCount = 5'd0;
    for (int k = 0; k < 2; k++) begin
      waitFor(1'b1, n);
      @(negedge clk);
      senseDone = 1'b1; senseDetect = 1'b0;
      @(negedge clk);
      senseDone = 1'b0;
      chk(tuneStrobe == 1'b1, "R4 no detect tune", tuneStrobe, 1);
      chk(bandIdx == 4'd0, "R8 single subband wraps to 0", bandIdx, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule